// File: doc/BRIEF.md
# Interval-Spread Pulse Output FIFO

The block drives four pulse output pins from sign bits that a computation engine writes. Two of the channels (A and B) are buffered. Their bits usually arrive in a burst near the start of each multiplexer frame. They are queued in a small FIFO and played out one at a time at a fixed spacing, so the pulse edges are spread across the frame and do not bunch at its start. The other two channels (C and D) are plain registers that load as soon as a bit is written.

The spacing comes from an 8-bit interval value, counted in units of four filter-clock ticks. The same value sets the delay from the frame-start strobe to the first play-out. A frame-start strobe empties the queue, restarts the spacing counter and clears the overflow flag. An interval of zero turns the queue off, and a buffered channel then loads straight from its write strobe. One global invert input selects the pin polarity for all four channels.

Top module: `pulse_spread_fifo`

## Requirements
- R1: After reset all four channel levels are 0, so with `invert_i`=0 `pulse_o` reads 4'b1111, and `overflow_o` is 0. The bit order of `pulse_o` is [0]=A, [1]=B, [2]=C, [3]=D.
- R2: Each pin shows the inverse of its channel level when `invert_i`=0 (a pulse is active low) and the level itself when `invert_i`=1 (a pulse is active high). The pin follows `invert_i` combinationally.
- R3: When `interval_i`=0, a write to channel A or B loads that channel's level at the clock edge that samples the write, and the FIFO is not used.
- R4: Ticks are counted from the clock after a frame-start strobe. With `interval_i`=N>0, the first play-out happens at the edge that samples the 4N-th `tick_i`. Clock cycles without a tick do not count.
- R5: Later play-outs follow every 4N ticks, in the order the bits were written. When A and B are both written in the same cycle, A is queued ahead of B.
- R6: Each queued entry carries a channel tag. A play-out updates only the channel named by the tag.
- R7: A frame-start strobe discards every queued entry that has not yet been played out. Writes made in the same cycle as the strobe are kept.
- R8: The FIFO holds 8 entries. A write that arrives while 8 entries were held at the start of the cycle is dropped and sets `overflow_o`. `overflow_o` stays set until the next frame-start strobe.
- R9: A write to channel C or D loads that channel's level at the edge that samples it, whatever the value of `interval_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Frame-start strobe, one cycle |
| tick_i | input | 1 | Filter-clock tick enable |
| interval_i | input | 8 | Play-out spacing in units of 4 ticks, 0 = bypass |
| invert_i | input | 1 | Global polarity select, 1 = active-high pulses |
| wr_a_i | input | 1 | Write strobe, buffered channel A |
| sign_a_i | input | 1 | Sign bit for channel A |
| wr_b_i | input | 1 | Write strobe, buffered channel B |
| sign_b_i | input | 1 | Sign bit for channel B |
| wr_c_i | input | 1 | Write strobe, direct channel C |
| sign_c_i | input | 1 | Sign bit for channel C |
| wr_d_i | input | 1 | Write strobe, direct channel D |
| sign_d_i | input | 1 | Sign bit for channel D |
| pulse_o | output | 4 | Pulse pins {D,C,B,A} |
| overflow_o | output | 1 | A buffered write was dropped this frame |

## Verification
A bypass or direct write is due at the pin one edge after it is sampled. The overflow flag sets on the edge that samples the dropped write. A queued bit is due on the edge that samples the 4N-th tick after the frame-start cycle. The invert select acts at once. The bench drives inputs and samples outputs on the falling edge, so a result due at rising edge k is read on the falling edge just after it. In the timing scenarios the bench also reads the pin one falling edge earlier and expects the old value there, which pins the play-out to its exact edge. One scenario spaces the ticks three clocks apart, to show that clocks without a tick are not counted.

// File: rtl/pulse_spread_pkg.sv
// Shared types for the interval-spread pulse block.
// Assumes a single clock domain; tag 0 names channel A, tag 1 channel B.
package pulse_spread_pkg;
    typedef struct packed {
        logic tag;   // 0 = channel A, 1 = channel B
        logic sign;  // exported sign bit
    } pulse_entry_t;
endpackage

// File: rtl/pulse_entry_fifo.sv
// Circular queue of tagged sign bits. It accepts up to two pushes per cycle
// (port 0 is queued ahead of port 1) and one pop. Clear empties it, and
// pushes in the clear cycle still land. Fullness is judged on the count held
// at the start of the cycle. Assumes DEPTH is a power of two.
module pulse_entry_fifo
    import pulse_spread_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         push0_i,
    input  pulse_entry_t data0_i,
    input  logic         push1_i,
    input  pulse_entry_t data1_i,
    input  logic         pop_i,
    output pulse_entry_t head_o,
    output logic         empty_o,
    output logic         ovf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    pulse_entry_t   mem [DEPTH];
    logic [AW-1:0]  rptr, wptr, rptr_b, wptr_b, wptr_1;
    logic [CW-1:0]  cnt, cnt_b, cnt_n;
    logic           ovf_b, acc0, acc1, pop_ok;

    // Base state for this cycle: clear wins over the held state.
    always_comb begin
        rptr_b = clear_i ? '0 : rptr;
        wptr_b = clear_i ? '0 : wptr;
        cnt_b  = clear_i ? '0 : cnt;
        ovf_b  = clear_i ? 1'b0 : ovf_o;
    end

    // Acceptance of each push, and the next count.
    always_comb begin
        pop_ok = pop_i && !clear_i && (cnt != '0);
        acc0   = push0_i && (cnt_b < CW'(DEPTH));
        acc1   = push1_i && ((cnt_b + CW'(acc0)) < CW'(DEPTH));
        wptr_1 = wptr_b + AW'(acc0);
        cnt_n  = cnt_b + CW'(acc0) + CW'(acc1) - CW'(pop_ok);
    end

    // Pointer, count and overflow state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            cnt   <= '0;
            ovf_o <= 1'b0;
        end else begin
            rptr  <= rptr_b + AW'(pop_ok);
            wptr  <= wptr_b + AW'(acc0) + AW'(acc1);
            cnt   <= cnt_n;
            ovf_o <= ovf_b | (push0_i & ~acc0) | (push1_i & ~acc1);
        end
    end

    // Entry storage writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (acc0 && wptr_b == AW'(i))
                mem[i] <= data0_i;
            else if (acc1 && wptr_1 == AW'(i))
                mem[i] <= data1_i;
        end
    end

    assign head_o  = mem[rptr];
    assign empty_o = (cnt == '0);

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> cnt <= CW'(2));
    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(cnt) >= CW'(DEPTH - 1) && $past(push0_i || push1_i));
endmodule

// File: rtl/pulse_interval_timer.sv
// Counts filter-clock ticks from the frame-start strobe and fires once every
// 4*interval ticks. It never fires while the interval is zero. Assumes
// frame_start_i lasts one cycle; that cycle resets the count and is not
// counted as a tick.
module pulse_interval_timer #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start_i,
    input  logic          tick_i,
    input  logic [IW-1:0] interval_i,
    output logic          expire_o
);
    localparam int CW = IW + 2;

    logic [CW-1:0] tick_cnt;
    logic [CW-1:0] limit_m1;

    // Last count value before expiry: 4*interval - 1.
    always_comb limit_m1 = {interval_i, 2'b00} - CW'(1);

    // Expiry strobe.
    always_comb expire_o = tick_i && !frame_start_i &&
                           (interval_i != '0) && (tick_cnt == limit_m1);

    // Tick counter, restarted by frame start and on each expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (frame_start_i || expire_o)
            tick_cnt <= '0;
        else if (tick_i)
            tick_cnt <= tick_cnt + CW'(1);
    end

    p_expire_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> tick_i && !frame_start_i);
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> !expire_o || interval_i == IW'(1) || interval_i == '0);
endmodule

// File: rtl/pulse_out_stage.sv
// Holds one level flip-flop per channel and applies the global polarity
// select at the pins. Assumes at most one load request per channel per cycle.
module pulse_out_stage #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] load_i,
    input  logic [NCH-1:0] value_i,
    input  logic           invert_i,
    output logic [NCH-1:0] level_o,
    output logic [NCH-1:0] pulse_o
);
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            // Per-channel level register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    level_o[g] <= 1'b0;
                else if (load_i[g])
                    level_o[g] <= value_i[g];
            end
        end
    endgenerate

    // Polarity select at the pins.
    always_comb pulse_o = invert_i ? level_o : ~level_o;
endmodule

// File: rtl/pulse_spread_fifo.sv
// Top level. Channels A and B are queued and played out on timer expiry, or
// loaded at once when the interval is zero. Channels C and D always load at
// once. Pin order is {D,C,B,A}.
module pulse_spread_fifo
    import pulse_spread_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start_i,
    input  logic          tick_i,
    input  logic [IW-1:0] interval_i,
    input  logic          invert_i,
    input  logic          wr_a_i,
    input  logic          sign_a_i,
    input  logic          wr_b_i,
    input  logic          sign_b_i,
    input  logic          wr_c_i,
    input  logic          sign_c_i,
    input  logic          wr_d_i,
    input  logic          sign_d_i,
    output logic [3:0]    pulse_o,
    output logic          overflow_o
);
    localparam int NCH = 4;

    logic         bypass, expire, fifo_empty, pop_fire;
    pulse_entry_t head, ent_a, ent_b;
    logic [NCH-1:0] load, value, level;

    // Mode decode and entries for the queue.
    always_comb begin
        bypass   = (interval_i == '0);
        ent_a    = '{tag: 1'b0, sign: sign_a_i};
        ent_b    = '{tag: 1'b1, sign: sign_b_i};
        pop_fire = expire && !fifo_empty;
    end

    pulse_interval_timer #(.IW(IW)) timer_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .tick_i        (tick_i),
        .interval_i    (interval_i),
        .expire_o      (expire)
    );

    pulse_entry_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (frame_start_i),
        .push0_i (wr_a_i && !bypass),
        .data0_i (ent_a),
        .push1_i (wr_b_i && !bypass),
        .data1_i (ent_b),
        .pop_i   (expire),
        .head_o  (head),
        .empty_o (fifo_empty),
        .ovf_o   (overflow_o)
    );

    // Load requests per channel: bypass write, tagged play-out, or direct.
    always_comb begin
        load[0]  = bypass ? wr_a_i : (pop_fire && !head.tag);
        value[0] = bypass ? sign_a_i : head.sign;
        load[1]  = bypass ? wr_b_i : (pop_fire && head.tag);
        value[1] = bypass ? sign_b_i : head.sign;
        load[2]  = wr_c_i;
        value[2] = sign_c_i;
        load[3]  = wr_d_i;
        value[3] = sign_d_i;
    end

    pulse_out_stage #(.NCH(NCH)) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .value_i  (value),
        .invert_i (invert_i),
        .level_o  (level),
        .pulse_o  (pulse_o)
    );

    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a_i && interval_i == '0 |=> level[0] == $past(sign_a_i));
    p_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c_i |=> level[2] == $past(sign_c_i));
    p_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_fire && !head.tag |=> $stable(level[1]));
    p_polarity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        invert_i |-> pulse_o == level);
endmodule

// File: tb/pulse_spread_fifo_tb_top.sv
module pulse_spread_fifo_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic frame_start_i, tick_i, invert_i;
    logic [7:0] interval_i;
    logic wr_a_i, sign_a_i, wr_b_i, sign_b_i, wr_c_i, sign_c_i, wr_d_i, sign_d_i;
    logic [3:0] pulse_o;
    logic overflow_o;
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    pulse_spread_fifo dut_i (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        frame_start_i = 0; tick_i = 0; invert_i = 0; interval_i = 0;
        wr_a_i = 0; sign_a_i = 0; wr_b_i = 0; sign_b_i = 0;
        wr_c_i = 0; sign_c_i = 0; wr_d_i = 0; sign_d_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset();
        check(pulse_o == 4'hF, "R1", pulse_o, 4'hF);
        check(overflow_o == 1'b0, "R1", overflow_o, 0);
    endtask

    // R2: polarity select.
    task automatic t_invert();
        do_reset();
        invert_i = 1;
        #1 check(pulse_o == 4'h0, "R2", pulse_o, 4'h0);
        interval_i = 8'd9; wr_c_i = 1; sign_c_i = 1;
        @(negedge clk);
        wr_c_i = 0;
        check(pulse_o == 4'h4, "R2", pulse_o, 4'h4);
        invert_i = 0;
        #1 check(pulse_o == 4'hB, "R2", pulse_o, 4'hB);
    endtask

    // R3: bypass with a zero interval.
    task automatic t_bypass();
        do_reset();
        interval_i = 0; wr_a_i = 1; sign_a_i = 1;
        @(negedge clk);
        wr_a_i = 0;
        check(pulse_o == 4'hE, "R3", pulse_o, 4'hE);
        wr_b_i = 1; sign_b_i = 1;
        @(negedge clk);
        wr_b_i = 0;
        check(pulse_o == 4'hC, "R3", pulse_o, 4'hC);
    endtask

    // R4 R5 R6: two bits queued in one cycle, interval 2, a tick every clock.
    task automatic t_spread();
        do_reset();
        interval_i = 2; tick_i = 1; frame_start_i = 1;
        wr_a_i = 1; sign_a_i = 1; wr_b_i = 1; sign_b_i = 1;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            frame_start_i = 0; wr_a_i = 0; wr_b_i = 0;
            if (k == 8)  check(pulse_o == 4'hF, "R4", pulse_o, 4'hF);
            if (k == 9)  check(pulse_o == 4'hE, "R4", pulse_o, 4'hE);
            if (k == 9)  check(pulse_o[1] == 1'b1, "R6", pulse_o, 4'hE);
            if (k == 16) check(pulse_o == 4'hE, "R5", pulse_o, 4'hE);
            if (k == 17) check(pulse_o == 4'hC, "R5", pulse_o, 4'hC);
        end
    endtask

    // R4: only ticks count, here one tick every third clock, interval 1.
    task automatic t_sparse_tick();
        do_reset();
        interval_i = 1; frame_start_i = 1; wr_a_i = 1; sign_a_i = 1;
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            frame_start_i = 0; wr_a_i = 0;
            if (k == 12) check(pulse_o == 4'hF, "R4", pulse_o, 4'hF);
            if (k == 13) check(pulse_o == 4'hE, "R4", pulse_o, 4'hE);
            tick_i = (k % 3 == 0);
        end
    endtask

    // R7: a second frame start flushes the queued bit.
    task automatic t_flush();
        do_reset();
        interval_i = 2; tick_i = 1; frame_start_i = 1; wr_a_i = 1; sign_a_i = 1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            frame_start_i = (k == 4); wr_a_i = 0;
        end
        check(pulse_o == 4'hF, "R7", pulse_o, 4'hF);
    endtask

    // R8: the ninth write is dropped and flagged; the flag clears at frame start.
    task automatic t_overflow();
        do_reset();
        interval_i = 1; frame_start_i = 1;
        @(negedge clk);
        frame_start_i = 0;
        for (int i = 0; i < 9; i++) begin
            wr_a_i = 1; sign_a_i = ~i[0];
            @(negedge clk);
            if (i == 7) check(overflow_o == 1'b0, "R8", overflow_o, 0);
        end
        wr_a_i = 0;
        check(overflow_o == 1'b1, "R8", overflow_o, 1);
        tick_i = 1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 4) check(pulse_o == 4'hE, "R8", pulse_o, 4'hE);
        end
        check(pulse_o == 4'hF, "R8", pulse_o, 4'hF);
        frame_start_i = 1;
        @(negedge clk);
        frame_start_i = 0;
        check(overflow_o == 1'b0, "R8", overflow_o, 0);
    endtask

    // R9: direct channels load at once even with a long interval.
    task automatic t_direct();
        do_reset();
        interval_i = 8'd255;
        wr_c_i = 1; sign_c_i = 1; wr_d_i = 1; sign_d_i = 1;
        @(negedge clk);
        wr_c_i = 0; wr_d_i = 0;
        check(pulse_o == 4'h3, "R9", pulse_o, 4'h3);
        wr_d_i = 1; sign_d_i = 0;
        @(negedge clk);
        wr_d_i = 0;
        check(pulse_o == 4'hB, "R9", pulse_o, 4'hB);
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        t_reset();
        t_invert();
        t_bypass();
        t_spread();
        t_sparse_tick();
        t_flush();
        t_overflow();
        t_direct();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule